// File: doc/BRIEF.md
# Dual Countdown Timer

This peripheral holds two independent 24-bit timers behind a small 32-bit register bus. Each timer has a control word, a reload value and a prescaler. Setting a timer's run bit copies its reload value into its counter. The counter then steps down once for every (prescale + 1) clock cycles. When the count runs out, the timer's sticky status bit is set. A periodic timer then reloads and keeps going. A one-shot timer stops, and hardware clears its run bit.

Software clears a status bit by writing 1 to it. Each timer drives its own interrupt line, which is its status bit masked by its interrupt enable. The live count of the second timer can be read from a data register. The first timer is observed through its status bit and interrupt line.

The bus has no handshake. A write is taken on the clock edge where `bus_we` is high. The read data is registered, and it shows the register addressed in the previous cycle.

Top module: `dual_countdown_timer`

## Requirements
- R1: After synchronous reset, every register reads zero and both interrupt lines are low.
- R2: The control word layout is: bit 30 is run, bit 29 is interrupt enable, bit 27 is periodic (0 means one-shot), and bits 7:0 are the prescale value. All other bits read zero. Offsets not in the map (timer 0 control 0x00, timer 1 control 0x04, timer 0 reload 0x08, timer 1 reload 0x0C, timer 1 live count 0x14, status 0x18) read zero, and writes to them are ignored.
- R3: A write that sets run on a stopped timer copies the reload value into its counter. The live count register returns timer 1's counter in bits 23:0 and zero in the bits above.
- R4: A running counter steps down exactly once every (prescale + 1) clocks. The first step comes prescale + 1 clocks after the write that started the timer.
- R5: In one-shot mode, the step taken at count 1 (or at count 0) expires the timer: the counter becomes 0, the status bit is set, and the run bit reads back as 0.
- R6: In periodic mode, expiry reloads the counter from the reload value and the timer keeps running. Status is set again on every period, which lasts the reload value times (prescale + 1) clocks.
- R7: The status bit is set on expiry whatever the interrupt enable. The interrupt line equals status AND enable, delayed by one register stage.
- R8: Status bit 0 belongs to timer 0 and bit 1 to timer 1. Writing 1 to a bit clears it and writing 0 leaves it unchanged. An expiry in the same cycle as a clear wins, so the bit stays set.
- R9: Writing 0 to a control word stops that timer, and its counter then holds its value.
- R10: Writing the reload value while the timer runs leaves the current count untouched. The new value is used at the next reload.
- R11: Reload values are 24 bits wide. Written bits above bit 23 are dropped and read back as zero.
- R12: The two timers run independently. Starting, expiring or clearing one does not change the other's count or status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, taken on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| irq | output | 2 | Interrupt line per timer (bit 0 is timer 0) |

## Verification
A write acts at the edge where it is taken. The first counter step falls prescale + 1 edges after the start write. The status bit sets on the same edge as the expiring step. The interrupt line follows one edge after the status bit. Read data is due one edge after the address is presented, and it shows the register's value from just before that edge. The bench counts edges from each start write and issues each read so that its sampling edge is the one of interest. It takes all samples at the falling edge in between. In this way it pins a count to the exact edge where it changes: for example, it reads 3 and then 2 across the first prescaled step, and 1 and then the reload value across a periodic expiry.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Register offsets; software depends on these exact positions.
  localparam logic [7:0] OFF_CTL0 = 8'h00;
  localparam logic [7:0] OFF_CTL1 = 8'h04;
  localparam logic [7:0] OFF_LD0  = 8'h08;
  localparam logic [7:0] OFF_LD1  = 8'h0C;
  localparam logic [7:0] OFF_CNT1 = 8'h14;
  localparam logic [7:0] OFF_STAT = 8'h18;

  // Control word bit positions.
  localparam int RUN_BIT = 30;
  localparam int IE_BIT  = 29;
  localparam int PER_BIT = 27;

  typedef enum logic [2:0] {
    SEL_CTL0,
    SEL_CTL1,
    SEL_LD0,
    SEL_LD1,
    SEL_CNT1,
    SEL_STAT,
    SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_off(input logic [7:0] off);
    reg_sel_e s;
    case (off)
      OFF_CTL0: s = SEL_CTL0;
      OFF_CTL1: s = SEL_CTL1;
      OFF_LD0:  s = SEL_LD0;
      OFF_LD1:  s = SEL_LD1;
      OFF_CNT1: s = SEL_CNT1;
      OFF_STAT: s = SEL_STAT;
      default:  s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PSC_W-1:0] limit,
  output logic             tick
);

  logic [PSC_W-1:0] pcnt_q;

  // Compare with >= so that lowering the limit mid-run cannot skip a wrap.
  assign tick = run && (pcnt_q >= limit);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pcnt_q <= '0;
    end else if (tick) begin
      pcnt_q <= '0;
    end else begin
      pcnt_q <= pcnt_q + 1'b1;
    end
  end

  // R4: two steps on consecutive edges happen only with a divide-by-one setting
  assert_tick_gap_R4: assert property (@(posedge clk) disable iff (rst)
    tick |=> (!tick || limit == '0));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int CNT_W = 24,
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic             wr_run,
  input  logic             wr_ie,
  input  logic             wr_per,
  input  logic [PSC_W-1:0] wr_psc,
  input  logic             ld_we,
  input  logic [CNT_W-1:0] wr_load,
  output logic             run_o,
  output logic             ie_o,
  output logic             per_o,
  output logic [PSC_W-1:0] psc_o,
  output logic [CNT_W-1:0] load_o,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             run_q, ie_q, per_q;
  logic [PSC_W-1:0] psc_q;
  logic [CNT_W-1:0] load_q, cnt_q;
  logic             tick, start, halt, go, at_end, expire;

  tmr_prescale #(.PSC_W(PSC_W)) u_psc (
    .clk   (clk),
    .rst   (rst),
    .run   (run_q),
    .limit (psc_q),
    .tick  (tick)
  );

  assign start  = ctl_we && wr_run && !run_q;
  assign halt   = ctl_we && !wr_run;
  assign go     = tick && !halt;
  assign at_end = (cnt_q <= ONE);
  assign expire = go && at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      ie_q   <= 1'b0;
      per_q  <= 1'b0;
      psc_q  <= '0;
      load_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (ld_we) load_q <= wr_load;

      if (ctl_we) begin
        run_q <= wr_run;
        ie_q  <= wr_ie;
        per_q <= wr_per;
        psc_q <= wr_psc;
      end else if (expire && !per_q) begin
        run_q <= 1'b0;
      end

      if (start) begin
        cnt_q <= load_q;
      end else if (go) begin
        if (at_end) cnt_q <= per_q ? load_q : '0;
        else        cnt_q <= cnt_q - ONE;
      end
    end
  end

  assign run_o    = run_q;
  assign ie_o     = ie_q;
  assign per_o    = per_q;
  assign psc_o    = psc_q;
  assign load_o   = load_q;
  assign count_o  = cnt_q;
  assign expire_o = expire;

  // R5: a one-shot expiry leaves the timer stopped at zero
  assert_oneshot_stop_R5: assert property (@(posedge clk) disable iff (rst)
    expire && !per_q && !ctl_we |=> !run_q && cnt_q == '0);

  // R6: a periodic expiry restarts from the reload value
  assert_reload_R6: assert property (@(posedge clk) disable iff (rst)
    expire && per_q && !ctl_we |=> run_q && cnt_q == $past(load_q));

endmodule

// File: rtl/dual_countdown_timer.sv
module dual_countdown_timer #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 24,
  parameter int PSC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [1:0]        irq
);
  import tmr_pkg::*;

  localparam int NCH = 2;
  localparam logic [DATA_W-1:0] CTL_MASK =
      (DATA_W'(1) << RUN_BIT) | (DATA_W'(1) << IE_BIT) |
      (DATA_W'(1) << PER_BIT) | ((DATA_W'(1) << PSC_W) - DATA_W'(1));

  reg_sel_e          sel;
  logic [NCH-1:0]    ctl_we, ld_we, run_v, ie_v, per_v, expire_v;
  logic [PSC_W-1:0]  psc   [NCH];
  logic [CNT_W-1:0]  load  [NCH];
  logic [CNT_W-1:0]  cnt   [NCH];
  logic [DATA_W-1:0] ctl_rd[NCH];
  logic              stat_we;
  logic [NCH-1:0]    stat_q, irq_q;
  logic [DATA_W-1:0] rd_next, rdata_q;

  assign sel     = decode_off(8'(bus_addr));
  assign stat_we = bus_we && (sel == SEL_STAT);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam reg_sel_e CTL_SEL = (g == 0) ? SEL_CTL0 : SEL_CTL1;
    localparam reg_sel_e LD_SEL  = (g == 0) ? SEL_LD0  : SEL_LD1;

    assign ctl_we[g] = bus_we && (sel == CTL_SEL);
    assign ld_we[g]  = bus_we && (sel == LD_SEL);

    tmr_channel #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .ctl_we   (ctl_we[g]),
      .wr_run   (bus_wdata[RUN_BIT]),
      .wr_ie    (bus_wdata[IE_BIT]),
      .wr_per   (bus_wdata[PER_BIT]),
      .wr_psc   (bus_wdata[PSC_W-1:0]),
      .ld_we    (ld_we[g]),
      .wr_load  (bus_wdata[CNT_W-1:0]),
      .run_o    (run_v[g]),
      .ie_o     (ie_v[g]),
      .per_o    (per_v[g]),
      .psc_o    (psc[g]),
      .load_o   (load[g]),
      .count_o  (cnt[g]),
      .expire_o (expire_v[g])
    );

    assign ctl_rd[g] = (DATA_W'(run_v[g]) << RUN_BIT) |
                       (DATA_W'(ie_v[g])  << IE_BIT)  |
                       (DATA_W'(per_v[g]) << PER_BIT) |
                       DATA_W'(psc[g]);

    // Sticky status: an expiry beats a clear in the same cycle.
    always_ff @(posedge clk) begin
      if (rst)                           stat_q[g] <= 1'b0;
      else if (expire_v[g])              stat_q[g] <= 1'b1;
      else if (stat_we && bus_wdata[g])  stat_q[g] <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (rst) irq_q[g] <= 1'b0;
      else     irq_q[g] <= stat_q[g] && ie_v[g];
    end

    // R2: control readback keeps exactly the defined fields of the last write
    assert_ctl_rdbk_R2: assert property (@(posedge clk) disable iff (rst)
      ctl_we[g] |=> ctl_rd[g] == ($past(bus_wdata) & CTL_MASK));

    // R7: expiry always sets status
    assert_stat_set_R7: assert property (@(posedge clk) disable iff (rst)
      expire_v[g] |=> stat_q[g]);

    // R7: a masked timer never raises its line
    assert_irq_gate_R7: assert property (@(posedge clk) disable iff (rst)
      !ie_v[g] |=> !irq[g]);

    // R8: writing 1 clears status unless an expiry coincides
    assert_w1c_R8: assert property (@(posedge clk) disable iff (rst)
      stat_we && bus_wdata[g] && !expire_v[g] |=> !stat_q[g]);

    // R9: a stopped timer keeps its count
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
      !run_v[g] && !ctl_we[g] |=> $stable(cnt[g]));
  end

  always_comb begin
    case (sel)
      SEL_CTL0: rd_next = ctl_rd[0];
      SEL_CTL1: rd_next = ctl_rd[1];
      SEL_LD0:  rd_next = DATA_W'(load[0]);
      SEL_LD1:  rd_next = DATA_W'(load[1]);
      SEL_CNT1: rd_next = DATA_W'(cnt[1]);
      SEL_STAT: rd_next = DATA_W'(stat_q);
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_next;
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;

endmodule

// File: tb/dual_countdown_timer_tb.sv
module dual_countdown_timer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;

  // {offset, write data, expected readback}
  localparam logic [71:0] VEC [NVEC] = '{
    {8'h0C, 32'hFFFF_FFFF, 32'h00FF_FFFF},
    {8'h08, 32'h1234_5678, 32'h0034_5678},
    {8'h00, 32'h2000_0005, 32'h2000_0005},
    {8'h04, 32'h0800_00A0, 32'h0800_00A0},
    {8'h00, 32'h9F00_FF33, 32'h0800_0033},
    {8'h10, 32'hFFFF_FFFF, 32'h0000_0000},
    {8'h04, 32'h0000_0000, 32'h0000_0000},
    {8'h00, 32'h0000_0000, 32'h0000_0000},
    {8'h18, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq;

  int n_tests = 0;
  int n_fail  = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_countdown_timer u_dut (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // All bus tasks start and finish at a falling edge.
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a[4:0]; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a[4:0]; bus_we = 1'b0;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check("R1 irq", {30'd0, irq}, 32'd0);
    check("R1 rdata", bus_rdata, 32'd0);
    foreach (VEC[i]) begin
      if (i < 1) begin
        rd(8'h00, v); check("R1 ctl0", v, 0);
        rd(8'h04, v); check("R1 ctl1", v, 0);
        rd(8'h08, v); check("R1 ld0", v, 0);
        rd(8'h0C, v); check("R1 ld1", v, 0);
        rd(8'h14, v); check("R1 cnt1", v, 0);
        rd(8'h18, v); check("R1 stat", v, 0);
      end
    end

    // Register table walk (R2 fields and unmapped, R11 width, R8 status read-only zeros)
    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] a;
      a = VEC[i][71:64];
      wr(a, VEC[i][63:32]);
      rd(a, v);
      if (a == 8'h08 || a == 8'h0C) check("R11 reload width", v, VEC[i][31:0]);
      else if (a == 8'h18)          check("R8 status", v, VEC[i][31:0]);
      else                          check("R2 control/map", v, VEC[i][31:0]);
    end

    // One-shot timer 1, reload 5, prescale 0, interrupt enabled
    wr(8'h0C, 32'd5);
    wr(8'h04, 32'h6000_0000);               // start edge E0
    rd(8'h14, v); check("R3 start load", v, 32'd5);   // sampled E1
    check("R7 irq low early", {30'd0, irq}, 32'd0);
    cyc(4);                                 // after E5: status set, irq lags
    check("R7 irq lag", {30'd0, irq}, 32'd0);
    cyc(1);
    check("R7 irq raised", {30'd0, irq}, 32'd2);
    rd(8'h18, v); check("R5 status set", v, 32'd2);
    rd(8'h14, v); check("R5 count zero", v, 32'd0);
    rd(8'h04, v); check("R5 run cleared", v, 32'h2000_0000);
    wr(8'h18, 32'h1);
    rd(8'h18, v); check("R8 other bit kept", v, 32'd2);
    wr(8'h18, 32'h2);
    rd(8'h18, v); check("R8 cleared", v, 32'd0);
    check("R7 irq dropped", {30'd0, irq}, 32'd0);

    // Periodic timer 1, reload 3, prescale 2, no interrupt
    wr(8'h0C, 32'd3);
    wr(8'h04, 32'h4800_0002);               // E0
    cyc(2);
    rd(8'h14, v); check("R4 before first step", v, 32'd3);  // E3
    rd(8'h14, v); check("R4 after first step", v, 32'd2);   // E4
    cyc(4);
    rd(8'h18, v); check("R6 status before expiry", v, 32'd0); // E9
    rd(8'h18, v); check("R7 status without enable", v, 32'd2); // E10
    check("R7 irq masked", {30'd0, irq}, 32'd0);
    rd(8'h14, v); check("R6 reloaded", v, 32'd3);           // E11
    wr(8'h0C, 32'd6);                                       // E12
    rd(8'h14, v); check("R10 count untouched", v, 32'd2);   // E13
    cyc(4);
    rd(8'h14, v); check("R10 old period end", v, 32'd1);    // E18
    rd(8'h14, v); check("R10 new reload", v, 32'd6);        // E19
    wr(8'h04, 32'h0);
    rd(8'h04, v); check("R9 ctl cleared", v, 32'd0);
    rd(8'h14, v); check("R9 count held", v, 32'd6);
    cyc(10);
    rd(8'h14, v); check("R9 count still held", v, 32'd6);
    wr(8'h18, 32'h3);

    // Timer 0 periodic reload 4: clear coinciding with expiry
    wr(8'h08, 32'd4);
    wr(8'h00, 32'h4800_0000);               // E0, expiries E4,E8,E12
    cyc(7);
    wr(8'h18, 32'h1);                       // taken at E8
    rd(8'h18, v); check("R8 expiry wins", v, 32'd1);
    wr(8'h18, 32'h1);                       // E10
    rd(8'h18, v); check("R8 clear timer0", v, 32'd0);
    wr(8'h00, 32'h0);
    wr(8'h18, 32'h3);

    // Independence: timer 1 long run, timer 0 short one-shot with interrupt
    wr(8'h0C, 32'd100);
    wr(8'h04, 32'h4000_0000);               // Ea
    wr(8'h08, 32'd2);
    wr(8'h00, 32'h6000_0000);               // Ea+2
    cyc(3);
    check("R12 irq timer0 only", {30'd0, irq}, 32'd1);
    rd(8'h18, v); check("R12 status timer0 only", v, 32'd1);
    rd(8'h14, v); check("R12 timer1 count", v, 32'd94);
    wr(8'h00, 32'h0);
    wr(8'h04, 32'h0);
    wr(8'h18, 32'h3);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule